// File: doc/BRIEF.md
# Power-Mode-Aware Peripheral Clock Selector

This block produces the clock enable for a low-power peripheral domain. It chooses one of four sources: the main clock, the main clock divided by a programmable ratio, the internal system oscillator, or the 32 kHz low-frequency clock. The choice follows the current power mode and the way the main clock is configured. Each source arrives as a one-cycle strobe in the block's own clock. Every output is a strobe that marks one active edge of the domain clock.

The divider is applied only when the main clock comes from a high-speed source in the active modes. In every other case it is bypassed, whatever the divider code holds. One standby sub-mode stops the domain clock for every peripheral except two designated timers. Those timers have their own enable output, and it keeps carrying the 32 kHz clock. The selector moves to a new source only on an edge of the source it is leaving. A status output reports which source is feeding the domain.

Top module: `ulp_clk_sel`

## Requirements
- R1: While reset is held, `dom_tick` and `tmr_tick` are 0 and `active_src` is 7 (off). At the first clock edge after release, the block takes up the source that the inputs select.
- R2: In RUN (`pwr_mode`=0) or SLEEP (1) with `main_hs`=0, `main_lf`=0 and `osc_off`=0, the source is the main clock (`active_src`=0). `dom_tick` follows every `mclk_tick`, and `div_code` has no effect.
- R3: In RUN or SLEEP with `main_hs`=1, `main_lf`=0 and `osc_off`=0, `dom_tick` fires once every `div_code`+1 main-clock strobes. A nonzero code reports `active_src`=1. Code 0 is divide-by-1, which reports `active_src`=0 and passes every main strobe.
- R4: In RUN or SLEEP with `main_lf`=1 or `osc_off`=1, the source is the low-frequency clock (`active_src`=3) and the divider is ignored.
- R5: In STOP (`pwr_mode`=2), `div_code` and `main_hs` have no effect. The source is the system oscillator (`active_src`=2) when `osc_off_stop`=0, and the low-frequency clock (3) when it is 1.
- R6: In STANDBY (`pwr_mode`=3) with `stby_gate`=0, both `dom_tick` and `tmr_tick` follow `lf_tick`, and `active_src` is 3.
- R7: In STANDBY with `stby_gate`=1, `dom_tick` stays 0 and `active_src` reads 7, while `tmr_tick` keeps following `lf_tick`.
- R8: SHUTDOWN (`pwr_mode`=4) and the unused codes 5 to 7 turn both outputs off. From the next clock edge `active_src` reads 7, with no wait for a source edge.
- R9: A change to a new source other than off takes effect only at the clock edge that ends a strobe cycle of the current source. The status and the output enables keep the old source until then.
- R10: After a change of `div_code`, the divider count starts again from zero. With a new code of 1, no pulse comes in the cycle after the change, and a pulse comes in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; every strobe is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_mode | input | 3 | Power mode: 0 RUN, 1 SLEEP, 2 STOP, 3 STANDBY, 4 SHUTDOWN, 5-7 treated as SHUTDOWN |
| main_hs | input | 1 | Main clock runs from a high-speed source |
| main_lf | input | 1 | Main clock runs from the low-frequency clock |
| osc_off | input | 1 | System oscillator disabled in the active modes |
| osc_off_stop | input | 1 | System oscillator disabled in STOP |
| stby_gate | input | 1 | Gate the domain clock in STANDBY, except for the timers |
| div_code | input | DIV_W | Divider code; the ratio is code+1 |
| mclk_tick | input | 1 | One-cycle strobe per main-clock edge |
| osc_tick | input | 1 | One-cycle strobe per system-oscillator edge |
| lf_tick | input | 1 | One-cycle strobe per low-frequency clock edge |
| dom_tick | output | 1 | Domain clock enable for all peripherals |
| tmr_tick | output | 1 | Clock enable for the two designated timers |
| active_src | output | 3 | Active source: 0 main, 1 divided, 2 oscillator, 3 low-frequency, 7 off |

## Verification
The bench builds the block with the default `DIV_W`=3. This gives divide ratios from 1 to 8 and a count wide enough to show that a ratio change restarts the count rather than running on from the old value. The main strobe is high every cycle, the oscillator strobe comes every 4th cycle and the low-frequency strobe every 16th. The pulse count over a 64-cycle window therefore comes out exact for every source, whatever the phase. The 16-cycle low-frequency period leaves room to watch a pending source change wait for its edge.

// File: rtl/ulp_pkg.sv
package ulp_pkg;

    typedef enum logic [2:0] {
        SRC_MAIN = 3'd0,
        SRC_DIV  = 3'd1,
        SRC_OSC  = 3'd2,
        SRC_LF   = 3'd3,
        SRC_OFF  = 3'd7
    } src_e;

    localparam logic [2:0] MODE_RUN   = 3'd0;
    localparam logic [2:0] MODE_SLEEP = 3'd1;
    localparam logic [2:0] MODE_STOP  = 3'd2;
    localparam logic [2:0] MODE_STBY  = 3'd3;

endpackage

// File: rtl/ulp_src_sel.sv
module ulp_src_sel
    import ulp_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic [2:0]       pwr_mode,
    input  logic             main_hs,
    input  logic             main_lf,
    input  logic             osc_off,
    input  logic             osc_off_stop,
    input  logic             stby_gate,
    input  logic [DIV_W-1:0] div_code,
    output src_e             req_src,
    output logic             req_gate
);

    always_comb begin
        req_src  = SRC_OFF;
        req_gate = 1'b0;
        if (pwr_mode == MODE_RUN || pwr_mode == MODE_SLEEP) begin
            if (main_lf || osc_off) begin
                req_src = SRC_LF;
            end else if (main_hs && div_code != '0) begin
                req_src = SRC_DIV;
            end else begin
                req_src = SRC_MAIN;
            end
        end else if (pwr_mode == MODE_STOP) begin
            req_src = osc_off_stop ? SRC_LF : SRC_OSC;
        end else if (pwr_mode == MODE_STBY) begin
            req_src  = SRC_LF;
            req_gate = stby_gate;
        end
    end

endmodule

// File: rtl/ulp_div.sv
module ulp_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             mclk_tick,
    input  logic [DIV_W-1:0] ratio,
    output logic             pulse
);

    localparam logic [DIV_W-1:0] RATIO_RST = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] ratio;
    } div_t;

    div_t st_d, st_q;
    logic ratio_same;

    always_comb begin
        st_d       = st_q;
        ratio_same = (ratio == st_q.ratio);
        st_d.ratio = ratio;
        if (!run || !ratio_same) begin
            st_d.cnt = '0;
        end else if (mclk_tick) begin
            st_d.cnt = (st_q.cnt == st_q.ratio) ? '0 : st_q.cnt + DIV_W'(1);
        end
        pulse = run && mclk_tick && ratio_same && (st_q.cnt == st_q.ratio);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.ratio <= RATIO_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: the count never passes the ratio it is measured against
    assert_cnt_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.ratio);

    // R3: a ratio above 1 never gives two pulses in a row
    assert_pulse_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && st_q.ratio != '0) |=> !pulse);

endmodule

// File: rtl/ulp_clk_sel.sv
module ulp_clk_sel
    import ulp_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       pwr_mode,
    input  logic             main_hs,
    input  logic             main_lf,
    input  logic             osc_off,
    input  logic             osc_off_stop,
    input  logic             stby_gate,
    input  logic [DIV_W-1:0] div_code,
    input  logic             mclk_tick,
    input  logic             osc_tick,
    input  logic             lf_tick,
    output logic             dom_tick,
    output logic             tmr_tick,
    output logic [2:0]       active_src
);

    typedef struct packed {
        src_e src;
        logic gate;
    } sel_t;

    sel_t sel_d, sel_q;
    src_e req_src;
    logic req_gate;
    logic div_pulse;
    logic act_tick;
    logic pending;

    ulp_src_sel #(.DIV_W(DIV_W)) src_sel_i (
        .pwr_mode     (pwr_mode),
        .main_hs      (main_hs),
        .main_lf      (main_lf),
        .osc_off      (osc_off),
        .osc_off_stop (osc_off_stop),
        .stby_gate    (stby_gate),
        .div_code     (div_code),
        .req_src      (req_src),
        .req_gate     (req_gate)
    );

    ulp_div #(.DIV_W(DIV_W)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (sel_q.src == SRC_DIV),
        .mclk_tick (mclk_tick),
        .ratio     (div_code),
        .pulse     (div_pulse)
    );

    always_comb begin
        case (sel_q.src)
            SRC_MAIN: act_tick = mclk_tick;
            SRC_DIV:  act_tick = div_pulse;
            SRC_OSC:  act_tick = osc_tick;
            SRC_LF:   act_tick = lf_tick;
            default:  act_tick = 1'b0;
        endcase

        sel_d   = sel_q;
        pending = (req_src != sel_q.src) || (req_gate != sel_q.gate);
        if (pending && (sel_q.src == SRC_OFF || req_src == SRC_OFF || act_tick)) begin
            sel_d.src  = req_src;
            sel_d.gate = req_gate;
        end

        dom_tick   = act_tick && !sel_q.gate;
        tmr_tick   = sel_q.gate ? lf_tick : dom_tick;
        active_src = sel_q.gate ? SRC_OFF : sel_q.src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q.src  <= SRC_OFF;
            sel_q.gate <= 1'b0;
        end else begin
            sel_q <= sel_d;
        end
    end

    // R9: the source changes only after an edge of the old one, or away from off
    assert_switch_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q.src != $past(sel_q.src)) |->
            ($past(act_tick) || $past(sel_q.src) == SRC_OFF || sel_q.src == SRC_OFF));

    // R8: shutdown and unused codes turn everything off by the next edge
    assert_off_in_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode >= 3'd4) |=> (active_src == 3'd7 && !dom_tick && !tmr_tick));

    // R7: gated standby leaves only the timers clocked
    assert_timer_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == MODE_STBY && stby_gate && $past(pwr_mode == MODE_STBY && stby_gate)
         && $past(active_src == 3'd7)) |-> (!dom_tick && tmr_tick == lf_tick));

endmodule

// File: tb/ulp_clk_sel_tb_top.sv
`timescale 1ns/1ps
module ulp_clk_sel_tb_top;

    localparam int DIV_W = 3;
    localparam int WIN   = 64;
    localparam int NVEC  = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       pwr_mode = 3'd0;
    logic             main_hs = 1'b0, main_lf = 1'b0, osc_off = 1'b0;
    logic             osc_off_stop = 1'b0, stby_gate = 1'b0;
    logic [DIV_W-1:0] div_code = '0;
    logic             mclk_tick = 1'b0, osc_tick = 1'b0, lf_tick = 1'b0;
    logic             dom_tick, tmr_tick;
    logic [2:0]       active_src;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_dom, n_tmr;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ulp_clk_sel #(.DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .main_hs(main_hs),
        .main_lf(main_lf), .osc_off(osc_off), .osc_off_stop(osc_off_stop),
        .stby_gate(stby_gate), .div_code(div_code), .mclk_tick(mclk_tick),
        .osc_tick(osc_tick), .lf_tick(lf_tick), .dom_tick(dom_tick),
        .tmr_tick(tmr_tick), .active_src(active_src)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [2:0] mode;
        logic       hs, lf, oo, oos, sg;
        logic [2:0] code;
        logic [2:0] st;
        logic [7:0] ndom, ntmr;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{4'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 3'd0, 8'd64, 8'd64}, // R2
        '{4'd2, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 8'd64, 8'd64}, // R2
        '{4'd3, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd1, 8'd32, 8'd32}, // R3
        '{4'd3, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 3'd1, 8'd8,  8'd8},  // R3
        '{4'd3, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 8'd64, 8'd64}, // R3
        '{4'd4, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 3'd3, 8'd4,  8'd4},  // R4
        '{4'd4, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 3'd3, 8'd4,  8'd4},  // R4
        '{4'd5, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd2, 8'd16, 8'd16}, // R5
        '{4'd5, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd3, 3'd3, 8'd4,  8'd4},  // R5
        '{4'd6, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd3, 8'd4,  8'd4},  // R6
        '{4'd7, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 3'd7, 8'd0,  8'd4},  // R7
        '{4'd8, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd7, 8'd0,  8'd0},  // R8
        '{4'd8, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd7, 8'd0,  8'd0},  // R8
        '{4'd8, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd7, 8'd0,  8'd0}   // R8
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        mclk_tick = 1'b1;
        osc_tick  = (cyc % 4 == 0);
        lf_tick   = (cyc % 16 == 0);
        @(negedge clk);
        if (dom_tick) n_dom++;
        if (tmr_tick) n_tmr++;
        cyc++;
    endtask

    task automatic apply(input vec_t v);
        pwr_mode = v.mode; main_hs = v.hs; main_lf = v.lf; osc_off = v.oo;
        osc_off_stop = v.oos; stby_gate = v.sg; div_code = v.code;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        n_dom = 0; n_tmr = 0;
        for (int i = 0; i < 6; i++) step();
        check("R1 dom during reset", n_dom, 0);
        check("R1 tmr during reset", n_tmr, 0);
        check("R1 status during reset", int'(active_src), 7);
        rst_n = 1'b1;
        step();
        check("R1 status after release", int'(active_src), 0);

        // table walk: settle, then count over an aligned window
        for (int k = 0; k < NVEC; k++) begin
            apply(VEC[k]);
            for (int i = 0; i < 40; i++) step();
            n_dom = 0; n_tmr = 0;
            for (int i = 0; i < WIN; i++) step();
            check($sformatf("R%0d vec%0d dom count", VEC[k].req, k), n_dom, int'(VEC[k].ndom));
            check($sformatf("R%0d vec%0d tmr count", VEC[k].req, k), n_tmr, int'(VEC[k].ntmr));
            check($sformatf("R%0d vec%0d status", VEC[k].req, k), int'(active_src), int'(VEC[k].st));
        end

        // R9: LF to main waits for the next low-frequency strobe
        pwr_mode = 3'd0; main_hs = 1'b0; main_lf = 1'b1; osc_off = 1'b0; div_code = 3'd0;
        for (int i = 0; i < 40; i++) step();
        while (cyc % 16 != 2) step();
        main_lf = 1'b0;
        n_dom = 0;
        for (int i = 0; i < 15; i++) step();
        check("R9 status held before lf edge", int'(active_src), 3);
        check("R9 ticks while pending", n_dom, 1);
        step();
        check("R9 status after lf edge", int'(active_src), 0);

        // R10: divider restart after a ratio change
        main_hs = 1'b1; div_code = 3'd7;
        for (int i = 0; i < 40; i++) step();
        n_dom = 0;
        while (n_dom == 0) step();
        for (int i = 0; i < 3; i++) step();
        div_code = 3'd1;
        n_dom = 0;
        step();
        check("R10 no pulse right after change", n_dom, 0);
        step();
        check("R10 pulse second cycle after change", n_dom, 1);
        check("R10 status divided", int'(active_src), 1);

        // R8: shutdown needs no source edge
        pwr_mode = 3'd4;
        step();
        check("R8 off on next edge", int'(active_src), 7);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule